// File: doc/BRIEF.md
# Endpoint loopback test controller

This block is a self-test function that sits behind a bus endpoint. A host programs a small bank of 32-bit registers through a flat register port. It then writes a command word that either fires an interrupt or starts a buffer move against host memory. Host memory is represented by a word-wide memory master port.

Three kinds of move are supported. A read sweeps a source buffer and folds every word into a 32-bit XOR checksum. A write fills a destination buffer with the sequence 1, 2, 3, … and records that sequence's checksum. A copy moves a source buffer to a destination buffer, reads the destination back and compares the two checksums. Each command ends with a single-cycle pulse on one of three interrupt lines, accompanied by a vector number. The outcome of the command is left in a status word for the host to read.

Addresses are range-checked against a fixed memory window before any memory access is made. Interrupt numbers are range-checked against the interrupt kind before any line is pulsed.

Top module: `ept_loopback_ctrl`

## Requirements
- R1: The scratch register at byte offset 0x00 returns exactly the last 32-bit value written to it, for any pattern.
- R2: Command bit 0, 1 or 2 (command register at offset 0x04) raises one interrupt of kind legacy, MSI or MSI-X respectively. The interrupt appears as a one-cycle pulse on `irq_legacy`, `irq_msi` or `irq_msix`, with `irq_vec` equal to the interrupt number register (offset 0x20). Only one line is ever high at a time.
- R3: An interrupt number is legal only as 0 for legacy, 1..32 for MSI and 1..2048 for MSI-X. An illegal number, or kind code 3, produces no pulse and leaves status bit 6 clear.
- R4: Command bit 3 reads size/4 words starting at the source address (offset 0x0C; size at offset 0x14, in bytes). It stores their XOR in the checksum register (offset 0x18, read-only) and sets status bit 0. A size of 0 gives checksum 0 and success.
- R5: Command bit 4 writes word i (counting from 0) of the destination buffer (offset 0x10) with the value i+1. It stores the XOR of those values as the checksum and sets status bit 2.
- R6: Command bit 5 copies the source buffer to the destination buffer and then re-reads the destination. Status bit 4 is set when the re-read XOR equals the source XOR, and bit 5 otherwise. The checksum register holds the source XOR.
- R7: An address is invalid when its low two bits are nonzero or when address + size exceeds 1024. An operation that uses an invalid address sets its fail bit (read 1, write 3, copy 5) together with status bit 7 (bad source) and/or bit 8 (bad destination). It leaves memory untouched and issues no memory access.
- R8: Read, write and copy completions raise an interrupt whose kind is taken from the type register (offset 0x1C; 0 legacy, 1 MSI, 2 MSI-X, 3 none). Status bit 6 is set in the cycle after the pulse.
- R9: The status register is at offset 0x08, and bit 9 reads 1 while a command is pending or running. A command write made during that time is ignored. Command bits read back as zero once accepted. Writing a nonzero command clears status bits 0..8.
- R10: When several command bits are set, only the lowest-numbered one is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| irq_legacy | output | 1 | Legacy interrupt pulse |
| irq_msi | output | 1 | MSI interrupt pulse |
| irq_msix | output | 1 | MSI-X interrupt pulse |
| irq_vec | output | 12 | Vector number accompanying a pulse |

## Verification
Raise commands are tried at each edge of every legal number range and one step beyond it. This separates an off-by-one range check from a correct one. Reads, writes and copies use distinct non-trivial buffer contents, a zero-length buffer, and a destination that ends exactly on the window edge versus one word past it. The copy is also run against a memory that flips one bit of one stored word, which shows the re-read comparison really examines the destination. A command issued while a copy is in progress, and a command word with two bits set, show the busy lockout and the lowest-bit priority.

// File: rtl/ept_pkg.sv
// Package: shared types and constants for the endpoint loopback test controller.
// Assumes a 32-bit register port addressed by byte offset.
package ept_pkg;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_CP = 2'd2
    } xfer_op_t;

    localparam logic [1:0] IRQ_LEG  = 2'd0;
    localparam logic [1:0] IRQ_MSI  = 2'd1;
    localparam logic [1:0] IRQ_MSIX = 2'd2;

    localparam int ST_IRQ     = 6;
    localparam int ST_SRC_BAD = 7;
    localparam int ST_DST_BAD = 8;
    localparam int ST_BUSY    = 9;

    localparam logic [5:0] A_MAGIC = 6'h00;
    localparam logic [5:0] A_CMD   = 6'h04;
    localparam logic [5:0] A_STAT  = 6'h08;
    localparam logic [5:0] A_SRC   = 6'h0C;
    localparam logic [5:0] A_DST   = 6'h10;
    localparam logic [5:0] A_SIZE  = 6'h14;
    localparam logic [5:0] A_CSUM  = 6'h18;
    localparam logic [5:0] A_ITYPE = 6'h1C;
    localparam logic [5:0] A_INUM  = 6'h20;

endpackage

// File: rtl/ept_window_chk.sv
// Module: decides whether a buffer (base, length in bytes) lies inside the
// memory window [0, MEM_BYTES) and starts on a word boundary.
// Assumes: purely combinational; the sum is widened so it cannot wrap.
module ept_window_chk #(
    parameter int AW        = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic          ok
);
    logic [AW:0] end_addr;

    // Widened end-of-buffer address and the alignment/window decision.
    always_comb begin
        end_addr = {1'b0, base} + {1'b0, len};
        ok = (base[1:0] == 2'b00) && (end_addr <= (AW+1)'(MEM_BYTES));
    end
endmodule

// File: rtl/ept_irq_gate.sv
// Module: checks that an interrupt number is legal for the chosen kind.
// Assumes: kind code 3 is never legal; purely combinational.
module ept_irq_gate
    import ept_pkg::*;
#(
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048
) (
    input  logic [1:0]  kind,
    input  logic [31:0] num,
    output logic        legal
);
    // Range decision per interrupt kind.
    always_comb begin
        case (kind)
            IRQ_LEG:  legal = (num == 32'd0);
            IRQ_MSI:  legal = (num >= 32'd1) && (num <= 32'(MSI_MAX));
            IRQ_MSIX: legal = (num >= 32'd1) && (num <= 32'(MSIX_MAX));
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ept_xfer_engine.sv
// Module: word-serial buffer engine for read, write and copy.
// Read folds source words into an XOR; write stores i+1 at word i;
// copy moves each word, then re-reads the destination to form a second XOR.
// Assumes: memory returns read data one cycle after a read request, and the
// caller has already checked both buffers against the window.
module ept_xfer_engine
    import ept_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int DW        = 32,
    parameter  int MEM_BYTES = 1024,
    localparam int NW        = $clog2(MEM_BYTES/4 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  xfer_op_t      op,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [NW-1:0] nwords,
    output logic          done,
    output logic          pass,
    output logic [DW-1:0] csum,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    typedef enum logic [2:0] {
        E_IDLE, E_RREQ, E_RDAT, E_WR, E_VREQ, E_VDAT, E_DONE
    } est_t;

    est_t          st;
    xfer_op_t      op_q;
    logic [AW-1:0] src_q, dst_q;
    logic [NW-1:0] n_q, idx;
    logic [DW-1:0] acc_s, acc_v, hold;
    logic [AW-1:0] offs;
    logic [DW-1:0] pat;
    logic          last;

    // Byte offset of the current word, write pattern and last-word flag.
    always_comb begin
        offs = AW'({idx, 2'b00});
        pat  = DW'(idx) + DW'(1);
        last = (idx == n_q - NW'(1));
    end

    // Memory port and result outputs decoded from the engine state.
    always_comb begin
        mem_req   = (st == E_RREQ) || (st == E_WR) || (st == E_VREQ);
        mem_we    = (st == E_WR);
        mem_addr  = (st == E_RREQ) ? (src_q + offs) : (dst_q + offs);
        mem_wdata = (op_q == OP_WR) ? pat : hold;
        done      = (st == E_DONE);
        pass      = (op_q != OP_CP) || (acc_s == acc_v);
        csum      = acc_s;
    end

    // Sequencer: walks the buffer word by word and folds checksums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= E_IDLE;
            op_q  <= OP_RD;
            src_q <= '0;
            dst_q <= '0;
            n_q   <= '0;
            idx   <= '0;
            acc_s <= '0;
            acc_v <= '0;
            hold  <= '0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    op_q  <= op;
                    src_q <= src;
                    dst_q <= dst;
                    n_q   <= nwords;
                    idx   <= '0;
                    acc_s <= '0;
                    acc_v <= '0;
                    if (nwords == '0)    st <= E_DONE;
                    else if (op == OP_WR) st <= E_WR;
                    else                 st <= E_RREQ;
                end
                E_RREQ: st <= E_RDAT;
                E_RDAT: begin
                    acc_s <= acc_s ^ mem_rdata;
                    if (op_q == OP_CP) begin
                        hold <= mem_rdata;
                        st   <= E_WR;
                    end else begin
                        idx <= idx + NW'(1);
                        st  <= last ? E_DONE : E_RREQ;
                    end
                end
                E_WR: begin
                    if (op_q == OP_WR) acc_s <= acc_s ^ pat;
                    if (last) begin
                        idx <= '0;
                        st  <= (op_q == OP_CP) ? E_VREQ : E_DONE;
                    end else begin
                        idx <= idx + NW'(1);
                        st  <= (op_q == OP_CP) ? E_RREQ : E_WR;
                    end
                end
                E_VREQ: st <= E_VDAT;
                E_VDAT: begin
                    acc_v <= acc_v ^ mem_rdata;
                    idx   <= idx + NW'(1);
                    st    <= last ? E_DONE : E_VREQ;
                end
                E_DONE:  st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // R7: every access the engine issues stays aligned and inside the window.
    p_mem_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00) && ({1'b0, mem_addr} < (AW+1)'(MEM_BYTES)));
endmodule

// File: rtl/ept_loopback_ctrl.sv
// Module: top of the endpoint loopback test controller. Holds the register
// bank, accepts commands, validates buffers, runs the transfer engine and
// pulses the selected interrupt line on completion.
// Assumes: single register master; register reads are combinational.
module ept_loopback_ctrl
    import ept_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int DW        = 32,
    parameter  int MEM_BYTES = 1024,
    parameter  int MSI_MAX   = 32,
    parameter  int MSIX_MAX  = 2048,
    localparam int NW        = $clog2(MEM_BYTES/4 + 1),
    localparam int VW        = $clog2(MSIX_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq_legacy,
    output logic          irq_msi,
    output logic          irq_msix,
    output logic [VW-1:0] irq_vec
);
    typedef enum logic [1:0] { T_IDLE, T_XFER, T_FIN } tst_t;

    tst_t          tst;
    logic [31:0]   magic_q, inum_q;
    logic [AW-1:0] src_q, dst_q, size_q;
    logic [DW-1:0] csum_q;
    logic [1:0]    itype_q, fin_kind;
    logic [5:0]    cmd_q;
    logic [8:0]    stat_q;
    xfer_op_t      cur_op, dec_op;
    logic [2:0]    sel;
    logic          is_raise, bad_src, bad_dst, src_ok, dst_ok;
    logic          busy, eng_start, eng_done, eng_pass, irq_legal, fire, irq_any;
    logic [DW-1:0] eng_csum;

    // Lowest set command bit wins; derive the move type it names.
    always_comb begin
        sel = '0;
        for (int i = 5; i >= 0; i--) if (cmd_q[i]) sel = 3'(i);
        is_raise = (sel < 3'd3);
        dec_op   = xfer_op_t'(2'(sel - 3'd3));
        bad_src  = !is_raise && (dec_op != OP_WR) && !src_ok;
        bad_dst  = !is_raise && (dec_op != OP_RD) && !dst_ok;
        busy      = (tst != T_IDLE) || (cmd_q != '0);
        eng_start = (tst == T_IDLE) && (cmd_q != '0) && !is_raise && !bad_src && !bad_dst;
    end

    ept_window_chk #(.AW(AW), .MEM_BYTES(MEM_BYTES)) u_src_chk (
        .base(src_q), .len(size_q), .ok(src_ok));
    ept_window_chk #(.AW(AW), .MEM_BYTES(MEM_BYTES)) u_dst_chk (
        .base(dst_q), .len(size_q), .ok(dst_ok));

    ept_irq_gate #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_gate (
        .kind(fin_kind), .num(inum_q), .legal(irq_legal));

    ept_xfer_engine #(.AW(AW), .DW(DW), .MEM_BYTES(MEM_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .op(dec_op),
        .src(src_q), .dst(dst_q), .nwords(size_q[NW+1:2]),
        .done(eng_done), .pass(eng_pass), .csum(eng_csum),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    // Interrupt pulse: only in the finish cycle and only for a legal number.
    always_comb begin
        fire       = (tst == T_FIN) && irq_legal;
        irq_legacy = fire && (fin_kind == IRQ_LEG);
        irq_msi    = fire && (fin_kind == IRQ_MSI);
        irq_msix   = fire && (fin_kind == IRQ_MSIX);
        irq_vec    = fire ? inum_q[VW-1:0] : '0;
        irq_any    = irq_legacy || irq_msi || irq_msix;
    end

    // Plain host-writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            magic_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            size_q  <= '0;
            itype_q <= '0;
            inum_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_MAGIC: magic_q <= reg_wdata;
                A_SRC:   src_q   <= reg_wdata;
                A_DST:   dst_q   <= reg_wdata;
                A_SIZE:  size_q  <= reg_wdata;
                A_ITYPE: itype_q <= reg_wdata[1:0];
                A_INUM:  inum_q  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Command acceptance, result bookkeeping and completion sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst      <= T_IDLE;
            cmd_q    <= '0;
            stat_q   <= '0;
            csum_q   <= '0;
            fin_kind <= IRQ_LEG;
            cur_op   <= OP_RD;
        end else begin
            case (tst)
                T_IDLE: begin
                    if (cmd_q != '0) begin
                        cmd_q  <= '0;
                        cur_op <= dec_op;
                        if (is_raise) begin
                            fin_kind <= sel[1:0];
                            tst      <= T_FIN;
                        end else begin
                            fin_kind <= itype_q;
                            if (bad_src || bad_dst) begin
                                stat_q[{dec_op, 1'b1}] <= 1'b1;
                                stat_q[ST_SRC_BAD]     <= bad_src;
                                stat_q[ST_DST_BAD]     <= bad_dst;
                                tst <= T_FIN;
                            end else begin
                                tst <= T_XFER;
                            end
                        end
                    end else if (reg_wr && reg_addr == A_CMD && reg_wdata[5:0] != '0) begin
                        cmd_q  <= reg_wdata[5:0];
                        stat_q <= '0;
                    end
                end
                T_XFER: if (eng_done) begin
                    stat_q[{cur_op, !eng_pass}] <= 1'b1;
                    csum_q <= eng_csum;
                    tst    <= T_FIN;
                end
                T_FIN: begin
                    stat_q[ST_IRQ] <= irq_legal;
                    tst            <= T_IDLE;
                end
                default: tst <= T_IDLE;
            endcase
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_MAGIC: reg_rdata = magic_q;
            A_CMD:   reg_rdata = {26'd0, cmd_q};
            A_STAT:  reg_rdata = {22'd0, busy, stat_q};
            A_SRC:   reg_rdata = src_q;
            A_DST:   reg_rdata = dst_q;
            A_SIZE:  reg_rdata = size_q;
            A_CSUM:  reg_rdata = csum_q;
            A_ITYPE: reg_rdata = {30'd0, itype_q};
            A_INUM:  reg_rdata = inum_q;
            default: reg_rdata = '0;
        endcase
    end

    // R2: at most one interrupt line is high in any cycle.
    p_irq_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_legacy, irq_msi, irq_msix}));
    // R2: an interrupt lasts exactly one cycle.
    p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |=> !irq_any);
    // R3: vectors stay within the legal range of the line that fires.
    p_legacy_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_legacy |-> (irq_vec == '0));
    p_msi_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msi |-> (irq_vec >= VW'(1)) && (irq_vec <= VW'(MSI_MAX)));
    p_msix_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msix |-> (irq_vec >= VW'(1)) && (irq_vec <= VW'(MSIX_MAX)));
    // R8: the raised flag appears only right after a pulse.
    p_flag_after_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_IRQ]) |-> $past(irq_any));
    // R6: copy never reports both success and failure.
    p_copy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q[4] && stat_q[5]));
    // R9: a command written while an operation runs is dropped.
    p_cmd_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tst != T_IDLE && reg_wr && reg_addr == A_CMD) |=> (cmd_q == '0));
endmodule

// File: tb/ept_loopback_ctrl_tb.sv
module ept_loopback_ctrl_tb;
    import ept_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq_legacy, irq_msi, irq_msix;
    logic [11:0] irq_vec;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mem [256];
    logic        corrupt_en = 1'b0;
    logic [31:0] corrupt_addr = '0;
    logic [13:0] exp_q [$];

    always #5 clk = ~clk;

    ept_loopback_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq_legacy(irq_legacy), .irq_msi(irq_msi),
        .irq_msix(irq_msix), .irq_vec(irq_vec));

    // Host memory model with an optional single-bit write fault.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we)
                mem[mem_addr[9:2]] <= mem_wdata ^ {31'd0, corrupt_en && (mem_addr == corrupt_addr)};
            else
                mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: each observed interrupt pulse is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && (irq_legacy || irq_msi || irq_msix)) begin
            logic [13:0] obs;
            obs = {irq_msix ? 2'd2 : (irq_msi ? 2'd1 : 2'd0), irq_vec};
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3 unexpected interrupt: actual %h expected none", obs);
            end else begin
                check("R2 interrupt kind/vector", 32'(obs), 32'(exp_q.pop_front()));
            end
            check("R2 single line", 32'($countones({irq_legacy, irq_msi, irq_msix})), 32'd1);
        end
    end

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_read(A_STAT, s);
            if (!s[ST_BUSY]) return;
        end
        check("R9 command never completed", 32'd1, 32'd0);
    endtask

    // Driver: push the expected pulse (if any), issue the command, wait for it.
    task automatic run(input logic [31:0] cmd, input bit want, input logic [1:0] k, input logic [11:0] v);
        if (want) exp_q.push_back({k, v});
        reg_write(A_CMD, cmd);
        wait_idle();
    endtask

    task automatic raise(input int bitn, input logic [31:0] num, input bit legal, input string req);
        logic [31:0] s;
        reg_write(A_INUM, num);
        run(32'd1 << bitn, legal, 2'(bitn), num[11:0]);
        reg_read(A_STAT, s);
        check(req, s, legal ? 32'h40 : 32'h0);
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] sz,
                         input logic [1:0] it, input logic [31:0] num);
        reg_write(A_SRC, src);
        reg_write(A_DST, dst);
        reg_write(A_SIZE, sz);
        reg_write(A_ITYPE, {30'd0, it});
        reg_write(A_INUM, num);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, src_x, wr_x;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        src_x = '0;
        for (int i = 0; i < 8; i++) begin
            mem[16 + i] = 32'hA5A5_0000 ^ (32'(i) * 32'h0011_0203) ^ 32'(i << 28);
            src_x ^= mem[16 + i];
        end
        mem[255] = 32'h5A5A_5A5A;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state (R9, R1)
        reg_read(A_STAT, r);  check("R9 reset status", r, 32'h0);
        reg_read(A_CMD, r);   check("R9 reset command", r, 32'h0);
        reg_read(A_MAGIC, r); check("R1 reset scratch", r, 32'h0);
        check("R2 idle lines", {29'd0, irq_legacy, irq_msi, irq_msix}, 32'h0);

        // R1 scratch patterns
        reg_write(A_MAGIC, 32'hDEAD_BEEF); reg_read(A_MAGIC, r); check("R1 pattern a", r, 32'hDEAD_BEEF);
        reg_write(A_MAGIC, 32'hFFFF_FFFF); reg_read(A_MAGIC, r); check("R1 pattern b", r, 32'hFFFF_FFFF);
        reg_write(A_MAGIC, 32'h0000_0001); reg_read(A_MAGIC, r); check("R1 pattern c", r, 32'h0000_0001);

        // R2/R3 raise commands at range edges; R9 result clearing
        raise(0, 32'd0,    1'b1, "R2 legacy num 0");
        raise(0, 32'd5,    1'b0, "R3 legacy num 5");
        raise(1, 32'd32,   1'b1, "R2 msi num 32");
        raise(1, 32'd33,   1'b0, "R3 msi num 33 and R9 result cleared");
        raise(1, 32'd0,    1'b0, "R3 msi num 0");
        raise(2, 32'd2048, 1'b1, "R2 msix num 2048");
        raise(2, 32'd2049, 1'b0, "R3 msix num 2049");

        // R4 read with completion over MSI (R8)
        setup(32'd64, 32'd0, 32'd32, 2'd1, 32'd3);
        run(32'h08, 1'b1, 2'd1, 12'd3);
        reg_read(A_STAT, r); check("R4 read status", r, 32'h41);
        reg_read(A_CSUM, r); check("R4 read checksum", r, src_x);

        // R4 zero-length read
        setup(32'd0, 32'd0, 32'd0, 2'd1, 32'd1);
        run(32'h08, 1'b1, 2'd1, 12'd1);
        reg_read(A_STAT, r); check("R4 empty read status", r, 32'h41);
        reg_read(A_CSUM, r); check("R4 empty read checksum", r, 32'h0);

        // R5 write, completion on legacy (R8)
        setup(32'd0, 32'd256, 32'd20, 2'd0, 32'd0);
        run(32'h10, 1'b1, 2'd0, 12'd0);
        reg_read(A_STAT, r); check("R5 write status", r, 32'h44);
        wr_x = '0;
        for (int i = 0; i < 5; i++) begin
            check("R5 written word", mem[64 + i], 32'(i + 1));
            wr_x ^= 32'(i + 1);
        end
        reg_read(A_CSUM, r); check("R5 write checksum", r, wr_x);

        // R7 write ending one word past the window: nothing written
        setup(32'd0, 32'd1020, 32'd8, 2'd0, 32'd0);
        run(32'h10, 1'b1, 2'd0, 12'd0);
        reg_read(A_STAT, r); check("R7 bad destination status", r, 32'h148);
        check("R7 memory untouched", mem[255], 32'h5A5A_5A5A);

        // R7 boundary: write ending exactly at the window edge is accepted
        setup(32'd0, 32'd1016, 32'd8, 2'd0, 32'd0);
        run(32'h10, 1'b1, 2'd0, 12'd0);
        reg_read(A_STAT, r); check("R7 edge write status", r, 32'h44);
        check("R7 edge write last word", mem[255], 32'd2);

        // R7 misaligned read source
        setup(32'd66, 32'd0, 32'd8, 2'd1, 32'd4);
        run(32'h08, 1'b1, 2'd1, 12'd4);
        reg_read(A_STAT, r); check("R7 bad source status", r, 32'hC2);

        // R7/R8 copy with both addresses bad and type 3: no pulse
        setup(32'd2, 32'd1024, 32'd4, 2'd3, 32'd1);
        run(32'h20, 1'b0, 2'd0, 12'd0);
        reg_read(A_STAT, r); check("R7 R8 both bad, no interrupt", r, 32'h1A0);

        // R6 good copy over MSI-X
        setup(32'd64, 32'd512, 32'd32, 2'd2, 32'd7);
        run(32'h20, 1'b1, 2'd2, 12'd7);
        reg_read(A_STAT, r); check("R6 copy status", r, 32'h50);
        reg_read(A_CSUM, r); check("R6 copy checksum", r, src_x);
        for (int i = 0; i < 8; i++) check("R6 copied word", mem[128 + i], mem[16 + i]);

        // R6 copy with a faulty destination word
        corrupt_en = 1'b1; corrupt_addr = 32'd524;
        run(32'h20, 1'b1, 2'd2, 12'd7);
        reg_read(A_STAT, r); check("R6 corrupted copy status", r, 32'h60);
        corrupt_en = 1'b0;

        // R9 busy lockout: a read issued during a copy is dropped
        reg_write(A_INUM, 32'd9);
        exp_q.push_back({2'd2, 12'd9});
        reg_write(A_CMD, 32'h20);
        reg_read(A_STAT, r); check("R9 busy flag", {31'd0, r[ST_BUSY]}, 32'd1);
        reg_write(A_CMD, 32'h08);
        wait_idle();
        reg_read(A_STAT, r); check("R9 locked-out command ignored", r, 32'h50);
        reg_read(A_CMD, r);  check("R9 command self-clears", r, 32'h0);

        // R10 two bits: MSI raise (bit 1) beats read (bit 3)
        reg_write(A_INUM, 32'd6);
        run(32'h0A, 1'b1, 2'd1, 12'd6);
        reg_read(A_STAT, r); check("R10 lowest bit wins", r, 32'h40);

        repeat (4) @(negedge clk);
        check("R2 all expected interrupts seen", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule